// File: doc/BRIEF.md
# Calibrated Period-Accumulation Time Converter

This block measures a small time offset carried by an external oscillator whose period stretches by the time of flight. It runs two back-to-back gated windows. Each window is exactly N periods of the variable clock. During each window a counter on the fixed reference clock counts how many reference cycles the window spans. The first window is a calibration run, with the oscillator at its zero-distance period. The second is the measurement run, with the oscillator period lengthened. Taking the difference of the two reference counts removes the fixed latencies and the nominal period, which leaves N times the offset. A sequential divider then scales the difference by the reference period in picoseconds over N.

The window is opened and closed in the variable-clock domain. The window level enters the reference domain through a two-flop synchronizer. Because the same synchronizer carries both the opening and the closing edge, its latency cancels within a window and again between the two runs. The `conv_phase` output tells the surrounding system which oscillator condition to apply. With a 20 ns reference and N = 10000, one count of difference is worth 2 ps.

Top module: `pacc_tdc`

## Requirements
- R1: After reset, `busy`, `valid`, `underflow` and `conv_phase` are 0 and `result_ps` is 0.
- R2: A `start` sampled high while idle with `period_n` of 1 or more makes `busy` high after that reference edge and captures `period_n` for the whole measurement. A `start` while idle with `period_n` equal to 0 is ignored and `busy` stays low.
- R3: A `start` while `busy` is high is ignored. The running measurement keeps its captured N, even if `period_n` changes, and no second measurement follows.
- R4: `conv_phase` is 0 during the calibration window and 1 during the measurement window. It is never 1 while idle.
- R5: In each run, the reference count equals the number of reference cycles spanned by exactly N variable-clock periods. The count is held while the window is closed.
- R6: When the measured count N2 is at least the calibration count N1, `result_ps` is the integer quotient (N2 − N1)·REF_PS / N, with `underflow` = 0.
- R7: When N2 < N1, `result_ps` is 0 and `underflow` is 1. A later non-negative result clears `underflow`.
- R8: `valid` is high for exactly one reference cycle. In that cycle `busy` is already low and `result_ps`/`underflow` already carry the new value, which is held until the next `valid`.
- R9: N = 1 is a legal boundary: each window is a single variable-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fixed reference clock (period REF_PS) |
| var_clk | input | 1 | Variable oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, reference timing |
| start | input | 1 | Measurement request, reference domain |
| period_n | input | N_W | Number N of variable periods per window |
| result_ps | output | CNT_W+PS_W | Offset in picoseconds |
| underflow | output | 1 | Measured count fell below calibration count |
| valid | output | 1 | One-cycle pulse when the result updates |
| busy | output | 1 | Measurement in progress |
| conv_phase | output | 1 | 0 = calibration window, 1 = measurement window |

## Verification
`busy` is due one reference edge after an accepted `start`, so the bench drives `start` on a falling edge and samples `busy` on the next falling edge. The result arrives a variable number of cycles later: two synchronizer stages, two windows, the drain handshakes and a divide of CNT_W+PS_W steps. The bench therefore polls `valid` on falling edges, with a bound, and samples `result_ps`, `underflow` and `busy` in that same half-cycle. It then checks on the next falling edge that `valid` has dropped and the result is held. The bench builds the variable clock from whole reference cycles, offset by a quarter period, so each window spans exactly N·gap reference cycles. This makes the expected result exact.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  typedef enum logic [1:0] {
    R_IDLE  = 2'd0,
    R_RUN   = 2'd1,
    R_DRAIN = 2'd2,
    R_DIV   = 2'd3
  } ref_st_e;

  typedef enum logic [1:0] {
    V_IDLE = 2'd0,
    V_GATE = 2'd1,
    V_DONE = 2'd2
  } var_st_e;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pacc_gate_ctrl.sv
module pacc_gate_ctrl
  import pacc_pkg::*;
#(
  parameter int N_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm,
  input  logic [N_W-1:0] n_lim,
  output logic           gate,
  output logic           done
);
  var_st_e        st;
  logic [N_W-1:0] b_cnt;
  logic           last_period;

  assign last_period = (b_cnt == n_lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= V_IDLE;
      b_cnt <= '0;
      gate  <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (st)
        V_IDLE: if (arm) begin
          gate  <= 1'b1;
          b_cnt <= '0;
          st    <= V_GATE;
        end
        V_GATE: begin
          if (last_period) begin
            gate <= 1'b0;
            done <= 1'b1;
            st   <= V_DONE;
          end else begin
            b_cnt <= b_cnt + 1'b1;
          end
        end
        V_DONE: if (!arm) begin
          done <= 1'b0;
          st   <= V_IDLE;
        end
        default: st <= V_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pacc_divider.sv
module pacc_divider #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem;
  logic [NUM_W-1:0] work;
  logic [DEN_W-1:0] den_q;
  logic [CW-1:0]    step_cnt;
  logic             running;
  logic [DEN_W:0]   trial;
  logic             take;

  function automatic logic [DEN_W:0] shift_in(input logic [DEN_W:0] r, input logic b);
    return {r[DEN_W-1:0], b};
  endfunction

  assign trial = shift_in(rem, work[NUM_W-1]);
  assign take  = (trial >= {1'b0, den_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem      <= '0;
      work     <= '0;
      den_q    <= '0;
      step_cnt <= '0;
      running  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !running) begin
        rem      <= '0;
        work     <= numer;
        den_q    <= denom;
        step_cnt <= '0;
        running  <= 1'b1;
      end else if (running) begin
        rem      <= take ? (trial - {1'b0, den_q}) : trial;
        work     <= {work[NUM_W-2:0], take};
        step_cnt <= step_cnt + 1'b1;
        if (step_cnt == CW'(NUM_W - 1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  assign quot = work;
endmodule

// File: rtl/pacc_tdc.sv
module pacc_tdc
  import pacc_pkg::*;
#(
  parameter int N_W    = 16,
  parameter int CNT_W  = 32,
  parameter int PS_W   = 16,
  parameter int REF_PS = 20000,
  localparam int RES_W = CNT_W + PS_W
) (
  input  logic             ref_clk,
  input  logic             var_clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N_W-1:0]   period_n,
  output logic [RES_W-1:0] result_ps,
  output logic             underflow,
  output logic             valid,
  output logic             busy,
  output logic             conv_phase
);
  ref_st_e          st;
  logic             run_ref;
  logic [CNT_W-1:0] acnt;
  logic [CNT_W-1:0] n1_hold;
  logic [CNT_W-1:0] n2_hold;
  logic [N_W-1:0]   n_hold;
  logic             gate_d;
  logic             div_go;

  logic             rst_v_n;
  logic             arm_v;
  logic             gate_v;
  logic             done_v;
  logic [1:0]       vflags_ref;
  logic             gate_ref;
  logic             done_ref;

  logic             accept;
  logic             phase_end;
  logic             cnt_clear;
  logic             res_load;
  logic             div_done;
  logic [RES_W-1:0] div_quot;
  logic [CNT_W:0]   diff_w;
  logic [RES_W-1:0] numer_w;

  function automatic logic [CNT_W:0] sat_diff(input logic [CNT_W-1:0] cal,
                                              input logic [CNT_W-1:0] meas);
    if (meas < cal) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, meas - cal};
  endfunction

  function automatic logic [RES_W-1:0] to_ps_units(input logic [CNT_W-1:0] mag);
    return RES_W'(mag) * RES_W'(REF_PS);
  endfunction

  pacc_sync #(.W(1), .STAGES(2)) u_vrst (
    .clk(var_clk), .rst_n(rst_n), .d(1'b1), .q(rst_v_n)
  );

  pacc_sync #(.W(1), .STAGES(2)) u_arm_sync (
    .clk(var_clk), .rst_n(rst_v_n), .d(run_ref), .q(arm_v)
  );

  pacc_gate_ctrl #(.N_W(N_W)) u_gate (
    .clk(var_clk), .rst_n(rst_v_n), .arm(arm_v), .n_lim(n_hold),
    .gate(gate_v), .done(done_v)
  );

  pacc_sync #(.W(2), .STAGES(2)) u_back_sync (
    .clk(ref_clk), .rst_n(rst_n), .d({done_v, gate_v}), .q(vflags_ref)
  );

  assign gate_ref = vflags_ref[0];
  assign done_ref = vflags_ref[1];

  assign diff_w  = sat_diff(n1_hold, n2_hold);
  assign numer_w = to_ps_units(diff_w[CNT_W-1:0]);

  pacc_divider #(.NUM_W(RES_W), .DEN_W(N_W)) u_div (
    .clk(ref_clk), .rst_n(rst_n), .go(div_go), .numer(numer_w),
    .denom(n_hold), .done(div_done), .quot(div_quot)
  );

  assign accept    = (st == R_IDLE) && start && (period_n != '0);
  assign phase_end = (st == R_RUN) && gate_d && !gate_ref;
  assign cnt_clear = accept || ((st == R_DRAIN) && !done_ref && !conv_phase);
  assign res_load  = (st == R_DIV) && div_done;
  assign busy      = (st != R_IDLE);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= R_IDLE;
      run_ref    <= 1'b0;
      conv_phase <= 1'b0;
      acnt       <= '0;
      n1_hold    <= '0;
      n2_hold    <= '0;
      n_hold     <= '0;
      gate_d     <= 1'b0;
      div_go     <= 1'b0;
      valid      <= 1'b0;
      result_ps  <= '0;
      underflow  <= 1'b0;
    end else begin
      valid  <= 1'b0;
      div_go <= 1'b0;
      gate_d <= gate_ref;
      case (st)
        R_IDLE: if (accept) begin
          n_hold     <= period_n;
          acnt       <= '0;
          run_ref    <= 1'b1;
          conv_phase <= 1'b0;
          st         <= R_RUN;
        end
        R_RUN: begin
          if (gate_ref) acnt <= acnt + 1'b1;
          if (phase_end) begin
            if (conv_phase) n2_hold <= acnt;
            else            n1_hold <= acnt;
            run_ref <= 1'b0;
            st      <= R_DRAIN;
          end
        end
        R_DRAIN: if (!done_ref) begin
          if (!conv_phase) begin
            conv_phase <= 1'b1;
            acnt       <= '0;
            run_ref    <= 1'b1;
            st         <= R_RUN;
          end else begin
            div_go <= 1'b1;
            st     <= R_DIV;
          end
        end
        R_DIV: if (div_done) begin
          result_ps  <= div_quot;
          underflow  <= diff_w[CNT_W];
          valid      <= 1'b1;
          conv_phase <= 1'b0;
          st         <= R_IDLE;
        end
        default: st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pacc_tdc_chk.sv
module pacc_tdc_chk #(
  parameter int N_W   = 16,
  parameter int CNT_W = 32,
  parameter int RES_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [N_W-1:0]   period_n,
  input logic             busy,
  input logic             valid,
  input logic             underflow,
  input logic [RES_W-1:0] result_ps,
  input logic             conv_phase,
  input logic             gate_ref,
  input logic             cnt_clear,
  input logic             res_load,
  input logic [CNT_W-1:0] acnt,
  input logic [N_W-1:0]   n_hold
);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && period_n != '0) |=> busy);
  // R2
  zero_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && period_n == '0) |=> !busy);
  // R3
  hold_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(n_hold));
  // R4
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !conv_phase);
  // R5
  acnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !gate_ref && !cnt_clear) |=> $stable(acnt));
  // R7
  uf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (result_ps == '0));
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_load |=> $stable(result_ps));
endmodule

bind pacc_tdc pacc_tdc_chk #(.N_W(N_W), .CNT_W(CNT_W), .RES_W(RES_W)) u_chk (
  .clk(ref_clk), .rst_n(rst_n), .start(start), .period_n(period_n),
  .busy(busy), .valid(valid), .underflow(underflow), .result_ps(result_ps),
  .conv_phase(conv_phase), .gate_ref(gate_ref), .cnt_clear(cnt_clear),
  .res_load(res_load), .acnt(acnt), .n_hold(n_hold)
);

// File: tb/pacc_tdc_test.sv
`timescale 1ns/1ps
module pacc_tdc_test;
  localparam int N_W   = 16;
  localparam int CNT_W = 32;
  localparam int PS_W  = 16;
  localparam int RPS   = 20000;
  localparam int RES_W = CNT_W + PS_W;

  logic             ref_clk = 1'b0;
  logic             var_clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [N_W-1:0]   period_n = '0;
  logic [RES_W-1:0] result_ps;
  logic             underflow, valid, busy, conv_phase;

  int g_cal = 2;
  int g_conv = 3;
  int checks = 0;
  int fails = 0;

  pacc_tdc #(.N_W(N_W), .CNT_W(CNT_W), .PS_W(PS_W), .REF_PS(RPS)) uut (
    .ref_clk(ref_clk), .var_clk(var_clk), .rst_n(rst_n), .start(start),
    .period_n(period_n), .result_ps(result_ps), .underflow(underflow),
    .valid(valid), .busy(busy), .conv_phase(conv_phase)
  );

  always #2 ref_clk = ~ref_clk;

  // variable clock: whole reference cycles per period, edges 1 ns after ref edges
  initial begin
    #3;
    forever begin
      int gap;
      gap = conv_phase ? g_conv : g_cal;
      var_clk = 1'b1;
      #2;
      var_clk = 1'b0;
      #(gap * 4 - 2);
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_ps(input int n, input int gc, input int gv);
    longint span_cal, span_conv;
    span_cal  = longint'(n) * gc;
    span_conv = longint'(n) * gv;
    if (span_conv < span_cal) return 0;
    return ((span_conv - span_cal) * RPS) / n;
  endfunction

  task automatic wait_valid(input string req, output bit seen_conv, output bit got);
    seen_conv = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge ref_clk);
      if (conv_phase) seen_conv = 1'b1;
      if (valid) begin
        got = 1'b1;
        break;
      end
    end
    if (!got) chk({req, " timeout waiting for valid"}, 0, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge ref_clk);
    chk("R1 busy", busy, 0);
    chk("R1 valid", valid, 0);
    chk("R1 underflow", underflow, 0);
    chk("R1 conv_phase", conv_phase, 0);
    chk("R1 result", result_ps, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge ref_clk);
  endtask

  task automatic t_zero_n();
    bit any_valid;
    period_n = '0;
    start = 1'b1;
    @(negedge ref_clk);
    start = 1'b0;
    chk("R2 zero N busy", busy, 0);
    any_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge ref_clk);
      if (valid || busy) any_valid = 1'b1;
    end
    chk("R2 zero N no activity", any_valid, 0);
  endtask

  task automatic t_measure(input string req, input int n, input int gc, input int gv,
                           input bit poke_busy);
    bit seen_conv, got;
    longint exp;
    exp = exp_ps(n, gc, gv);
    g_cal = gc;
    g_conv = gv;
    period_n = N_W'(n);
    start = 1'b1;
    @(negedge ref_clk);
    start = 1'b0;
    chk({req, " R2 busy after start"}, busy, 1);
    chk({req, " R4 calibration phase"}, conv_phase, 0);
    if (poke_busy) begin
      repeat (20) @(negedge ref_clk);
      period_n = 2;
      start = 1'b1;
      @(negedge ref_clk);
      start = 1'b0;
    end
    wait_valid(req, seen_conv, got);
    if (got) begin
      chk({req, " R6 result"}, result_ps, exp);
      chk({req, " R7 underflow"}, underflow, (gv < gc) ? 1 : 0);
      chk({req, " R8 busy low at valid"}, busy, 0);
      chk({req, " R4 conversion phase seen"}, seen_conv, 1);
      @(negedge ref_clk);
      chk({req, " R8 valid one cycle"}, valid, 0);
      chk({req, " R8 result held"}, result_ps, exp);
    end
    if (poke_busy) begin
      bit again;
      again = 1'b0;
      for (int i = 0; i < 60; i++) begin
        @(negedge ref_clk);
        if (busy || valid) again = 1'b1;
      end
      chk("R3 no second measurement", again, 0);
    end
    repeat (6) @(negedge ref_clk);
  endtask

  initial begin
    repeat (190000) @(posedge ref_clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_n();
    t_measure("R6 n10", 10, 2, 3, 1'b0);
    t_measure("R6 n4", 4, 2, 5, 1'b0);
    t_measure("R9 n1", 1, 3, 4, 1'b0);
    t_measure("R7 negative", 5, 4, 2, 1'b0);
    t_measure("R7 clear zero", 6, 2, 2, 1'b0);
    t_measure("R3 start while busy", 7, 3, 5, 1'b1);
    t_measure("R5 n300", 300, 2, 3, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule